// File: doc/BRIEF.md
# Two-Wire Write-Only Control Slave for a Frequency Synthesizer

This block receives write transfers from a two-wire serial bus and loads the settings of a frequency-synthesizer core: an 8-bit control byte, a 16-bit reference-divider ratio and a 16-bit main-divider ratio. All three are exposed as parallel outputs. The bus clock and data lines are brought in as plain levels, oversampled by a fast system clock, and the slave signals acknowledge through an open-drain enable output. It does not support read transfers.

The device answers only to one 7-bit address. Six of its bits are fixed and one follows a static strap input, so two such slaves can share a bus. After the address comes a selector byte. Two bits of that byte choose which group of data bytes follows: the control byte with the reference ratio, or the main ratio alone. Received bytes are held in staging registers. They reach the outputs only when the bus STOP condition arrives, so a divider never sees a half-written ratio.

Top module: `synth_ctl_i2c_slave`

## Requirements
- R1: While reset is asserted, and after it is released, `ctl_byte_o`, `ref_ratio_o` and `main_ratio_o` are zero and `sda_pull_o` is 0.
- R2: An address byte equal to binary 1100_10s0 (MSB first) is acknowledged by holding `sda_pull_o` high during the ninth clock. Here s is the level of `addr_strap_i`.
- R3: When the address differs from R2 (wrong strap bit, wrong fixed bit, or LSB 1 for read), no byte of that transfer is acknowledged and no output changes.
- R4: When selector bits [3:2] are 01, the next data bytes load the control byte, then the reference ratio high byte, then its low byte. The other selector bits are ignored.
- R5: When selector bits [3:2] are 11, the next data bytes load the main ratio high byte, then its low byte.
- R6: Bit i of the control byte appears on `ctl_byte_o[i]`. Bit 7 is the port line, bits 6..4 are switch lines 1..3, bit 3 is band select (1 = AM), bit 2 is detector test, bit 1 is detector polarity and bit 0 is detector current.
- R7: Outputs change only on a STOP. A repeated START keeps the bytes already staged, and they are committed together at the final STOP.
- R8: The control byte commits if it was received. A ratio commits only when both its high and low bytes were received in that transfer; otherwise the ratio keeps its old value.
- R9: Data bytes beyond the end of the selected group are acknowledged and discarded.
- R10: With selector bits [3:2] equal to 00 or 10, the selector and data bytes are acknowledged and the data is discarded.
- R11: In an addressed transfer, every byte (address, selector and data) is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| addr_strap_i | input | 1 | Static strap compared with the programmable address bit |
| sda_pull_o | output | 1 | 1 = pull the data line low (acknowledge) |
| ctl_byte_o | output | 8 | Committed control byte |
| ref_ratio_o | output | 16 | Committed reference-divider ratio |
| main_ratio_o | output | 16 | Committed main-divider ratio |

## Verification
On every cycle, the in-line properties check four things. Outputs stay frozen unless a STOP is seen. The acknowledge pull starts only while the bus clock is low. A rejected transfer never pulls the data line. Each START returns the receiver to the address phase. Other behaviour can only be shown by the bench's bus scenarios: which bytes land in which output, the pairing rule for ratios, the discarding of excess bytes and of unknown selector groups, and staging that survives a repeated START.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;
  localparam int BYTE_W  = 8;
  localparam int RATIO_W = 2 * BYTE_W;
  localparam logic [5:0] DEV_FIXED = 6'b110010;
  localparam logic [1:0] SEL_REF  = 2'b01;
  localparam logic [1:0] SEL_MAIN = 2'b11;

  typedef enum logic [2:0] {
    RX_IDLE, RX_ADDR, RX_SEL, RX_DATA, RX_SKIP
  } rx_state_e;

  typedef enum logic [1:0] {
    GRP_NONE, GRP_REF, GRP_MAIN
  } grp_e;

  typedef enum logic [2:0] {
    FLD_CTL, FLD_RHI, FLD_RLO, FLD_MHI, FLD_MLO, FLD_NONE
  } fld_e;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LAST = STAGES;

  logic [LAST:0] scl_sh, sda_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[LAST-1:0], scl_i};
      sda_sh <= {sda_sh[LAST-1:0], sda_i};
    end
  end

  logic scl_prev, sda_prev;
  assign scl_lvl  = scl_sh[LAST-1];
  assign sda_lvl  = sda_sh[LAST-1];
  assign scl_prev = scl_sh[LAST];
  assign sda_prev = sda_sh[LAST];

  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
  import synth_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              addr_strap,
  output logic              sda_pull,
  output logic              wr_en,
  output fld_e              wr_fld,
  output logic [BYTE_W-1:0] wr_data
);
  rx_state_e         state_q, state_d;
  grp_e              grp_q, grp_d;
  logic [3:0]        bit_cnt_q, bit_cnt_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [1:0]        ptr_q, ptr_d;
  logic              in_ack_q, in_ack_d;
  logic              pull_q, pull_d;
  logic              addr_ok;
  fld_e              fld_cur;

  assign addr_ok = (shreg_q[7:2] == DEV_FIXED) && (shreg_q[1] == addr_strap) && !shreg_q[0];

  always_comb begin
    fld_cur = FLD_NONE;
    case (grp_q)
      GRP_REF: begin
        if (ptr_q == 2'd0)      fld_cur = FLD_CTL;
        else if (ptr_q == 2'd1) fld_cur = FLD_RHI;
        else if (ptr_q == 2'd2) fld_cur = FLD_RLO;
      end
      GRP_MAIN: begin
        if (ptr_q == 2'd0)      fld_cur = FLD_MHI;
        else if (ptr_q == 2'd1) fld_cur = FLD_MLO;
      end
      default: fld_cur = FLD_NONE;
    endcase
  end

  always_comb begin
    state_d   = state_q;
    grp_d     = grp_q;
    bit_cnt_d = bit_cnt_q;
    shreg_d   = shreg_q;
    ptr_d     = ptr_q;
    in_ack_d  = in_ack_q;
    pull_d    = pull_q;
    wr_en     = 1'b0;
    if (stop_det) begin
      state_d  = RX_IDLE;
      in_ack_d = 1'b0;
      pull_d   = 1'b0;
    end else if (start_det) begin
      state_d   = RX_ADDR;
      bit_cnt_d = '0;
      in_ack_d  = 1'b0;
      pull_d    = 1'b0;
    end else if (state_q != RX_IDLE) begin
      if (scl_rise && !in_ack_q && bit_cnt_q < 4'd8) begin
        shreg_d   = {shreg_q[BYTE_W-2:0], sda_lvl};
        bit_cnt_d = bit_cnt_q + 4'd1;
      end
      if (scl_fall) begin
        if (in_ack_q) begin
          in_ack_d  = 1'b0;
          pull_d    = 1'b0;
          bit_cnt_d = '0;
        end else if (bit_cnt_q == 4'd8) begin
          in_ack_d = 1'b1;
          case (state_q)
            RX_ADDR: begin
              pull_d  = addr_ok;
              state_d = addr_ok ? RX_SEL : RX_SKIP;
            end
            RX_SEL: begin
              pull_d  = 1'b1;
              state_d = RX_DATA;
              ptr_d   = '0;
              if (shreg_q[3:2] == SEL_REF)       grp_d = GRP_REF;
              else if (shreg_q[3:2] == SEL_MAIN) grp_d = GRP_MAIN;
              else                               grp_d = GRP_NONE;
            end
            RX_DATA: begin
              pull_d = 1'b1;
              wr_en  = (fld_cur != FLD_NONE);
              if (ptr_q != 2'd3) ptr_d = ptr_q + 2'd1;
            end
            default: pull_d = 1'b0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      grp_q     <= GRP_NONE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      ptr_q     <= '0;
      in_ack_q  <= 1'b0;
      pull_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      grp_q     <= grp_d;
      bit_cnt_q <= bit_cnt_d;
      shreg_q   <= shreg_d;
      ptr_q     <= ptr_d;
      in_ack_q  <= in_ack_d;
      pull_q    <= pull_d;
    end
  end

  assign sda_pull = pull_q;
  assign wr_fld   = fld_cur;
  assign wr_data  = shreg_q;

  AST_PULL_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> !scl_lvl); // R11
  AST_SKIP_NEVER_PULLS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_SKIP) |-> !pull_q); // R3
  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == RX_ADDR && bit_cnt_q == 4'd0)); // R2
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !pull_q); // R7
endmodule

// File: rtl/synth_reg_bank.sv
module synth_reg_bank
  import synth_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  fld_e               wr_fld,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic               commit,
  output logic [BYTE_W-1:0]  ctl_o,
  output logic [RATIO_W-1:0] ref_o,
  output logic [RATIO_W-1:0] main_o
);
  logic [BYTE_W-1:0]  stg_ctl_q, stg_ctl_d, ctl_q, ctl_d;
  logic [RATIO_W-1:0] stg_ref_q, stg_ref_d, stg_main_q, stg_main_d;
  logic [RATIO_W-1:0] ref_q, ref_d, main_q, main_d;
  logic [4:0]         vld_q, vld_d;

  always_comb begin
    stg_ctl_d  = stg_ctl_q;
    stg_ref_d  = stg_ref_q;
    stg_main_d = stg_main_q;
    vld_d      = vld_q;
    ctl_d      = ctl_q;
    ref_d      = ref_q;
    main_d     = main_q;
    if (wr_en) begin
      case (wr_fld)
        FLD_CTL: begin stg_ctl_d = wr_data;                      vld_d[0] = 1'b1; end
        FLD_RHI: begin stg_ref_d[RATIO_W-1:BYTE_W] = wr_data;    vld_d[1] = 1'b1; end
        FLD_RLO: begin stg_ref_d[BYTE_W-1:0] = wr_data;          vld_d[2] = 1'b1; end
        FLD_MHI: begin stg_main_d[RATIO_W-1:BYTE_W] = wr_data;   vld_d[3] = 1'b1; end
        FLD_MLO: begin stg_main_d[BYTE_W-1:0] = wr_data;         vld_d[4] = 1'b1; end
        default: ;
      endcase
    end
    if (commit) begin
      if (vld_q[0])            ctl_d  = stg_ctl_q;
      if (vld_q[1] && vld_q[2]) ref_d  = stg_ref_q;
      if (vld_q[3] && vld_q[4]) main_d = stg_main_q;
      vld_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_ctl_q  <= '0;
      stg_ref_q  <= '0;
      stg_main_q <= '0;
      vld_q      <= '0;
      ctl_q      <= '0;
      ref_q      <= '0;
      main_q     <= '0;
    end else begin
      stg_ctl_q  <= stg_ctl_d;
      stg_ref_q  <= stg_ref_d;
      stg_main_q <= stg_main_d;
      vld_q      <= vld_d;
      if (commit) begin
        ctl_q  <= ctl_d;
        ref_q  <= ref_d;
        main_q <= main_d;
      end
    end
  end

  assign ctl_o  = ctl_q;
  assign ref_o  = ref_q;
  assign main_o = main_q;

  AST_HOLD_WITHOUT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(ctl_q) && $stable(ref_q) && $stable(main_q))); // R7
  AST_WRITE_NOT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !wr_en); // R7
endmodule

// File: rtl/synth_ctl_i2c_slave.sv
module synth_ctl_i2c_slave
  import synth_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               addr_strap_i,
  output logic               sda_pull_o,
  output logic [BYTE_W-1:0]  ctl_byte_o,
  output logic [RATIO_W-1:0] ref_ratio_o,
  output logic [RATIO_W-1:0] main_ratio_o
);
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  fld_e wr_fld;
  logic [BYTE_W-1:0] wr_data;

  i2c_line_cond #(.STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rx_fsm u_rx (
    .clk(clk), .rst_n(rst_n_s), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .addr_strap(addr_strap_i), .sda_pull(sda_pull_o),
    .wr_en(wr_en), .wr_fld(wr_fld), .wr_data(wr_data)
  );

  synth_reg_bank u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_fld(wr_fld),
    .wr_data(wr_data), .commit(stop_det), .ctl_o(ctl_byte_o),
    .ref_o(ref_ratio_o), .main_o(main_ratio_o)
  );
endmodule

// File: tb/synth_ctl_i2c_slave_tb.sv
module synth_ctl_i2c_slave_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic strap = 1'b0;
  logic sda_pull;
  logic sda_bus;
  logic [7:0]  ctl;
  logic [15:0] rref, rmain;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  synth_ctl_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_strap_i(strap), .sda_pull_o(sda_pull), .ctl_byte_o(ctl),
    .ref_ratio_o(rref), .main_ratio_o(rmain)
  );

  typedef struct packed {
    logic        asel;
    logic [7:0]  addr;
    logic [7:0]  sel;
    logic [1:0]  nb;
    logic [23:0] dat;
    logic        ack;
    logic [7:0]  e_ctl;
    logic [15:0] e_ref;
    logic [15:0] e_main;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'hC8, 8'h04, 2'd3, 24'hA51234, 1'b1, 8'hA5, 16'h1234, 16'h0000},
    '{1'b0, 8'hC8, 8'h0C, 2'd2, 24'hBEEF00, 1'b1, 8'hA5, 16'h1234, 16'hBEEF},
    '{1'b1, 8'hC8, 8'h04, 2'd3, 24'h112233, 1'b0, 8'hA5, 16'h1234, 16'hBEEF},
    '{1'b1, 8'hCA, 8'hF7, 2'd3, 24'h3C0002, 1'b1, 8'h3C, 16'h0002, 16'hBEEF},
    '{1'b1, 8'hCB, 8'h04, 2'd3, 24'h445566, 1'b0, 8'h3C, 16'h0002, 16'hBEEF},
    '{1'b1, 8'hCA, 8'h08, 2'd2, 24'h999800, 1'b1, 8'h3C, 16'h0002, 16'hBEEF},
    '{1'b1, 8'hCA, 8'h0C, 2'd3, 24'h123456, 1'b1, 8'h3C, 16'h0002, 16'h1234},
    '{1'b1, 8'hCA, 8'h04, 2'd1, 24'h7E0000, 1'b1, 8'h7E, 16'h0002, 16'h1234},
    '{1'b1, 8'hCA, 8'h04, 2'd2, 24'h81FF00, 1'b1, 8'h81, 16'h0002, 16'h1234},
    '{1'b0, 8'h8A, 8'h04, 2'd3, 24'h010203, 1'b0, 8'h81, 16'h0002, 16'h1234}
  };

  function automatic string row_tag(input int i);
    case (i)
      0: return "R4 R6 ref group";
      1: return "R5 main group";
      2: return "R3 strap mismatch";
      3: return "R4 ignored selector bits";
      4: return "R3 read direction";
      5: return "R10 unknown group";
      6: return "R9 excess byte";
      7: return "R8 control only";
      8: return "R8 half ratio";
      default: return "R3 wrong fixed bits";
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(10);
    scl_m = 1'b1; tick(10);
    sda_m = 1'b0; tick(10);
    scl_m = 1'b0; tick(10);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(10);
    scl_m = 1'b1; tick(10);
    sda_m = 1'b1; tick(10);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(10);
      scl_m = 1'b1; tick(20);
      scl_m = 1'b0; tick(10);
    end
    sda_m = 1'b1; tick(10);
    scl_m = 1'b1; tick(10);
    ack = ~sda_bus; tick(10);
    scl_m = 1'b0; tick(10);
  endtask

  task automatic byte_chk(input string tag, input logic [7:0] b, input logic exp_ack);
    logic a;
    send_byte(b, a);
    chk(tag, {31'd0, a}, {31'd0, exp_ack});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic a, any;
    tick(3);
    // R1: values during reset
    chk("R1 ctl in reset", {24'd0, ctl}, 32'd0);
    chk("R1 pull in reset", {31'd0, sda_pull}, 32'd0);
    rst_n = 1'b1;
    tick(6);
    chk("R1 ratios after reset", {rref, rmain}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      strap = VEC[i].asel;
      tick(4);
      bus_start();
      send_byte(VEC[i].addr, a);
      chk(VEC[i].ack ? "R2 address ack" : "R3 address no ack", {31'd0, a}, {31'd0, VEC[i].ack});
      send_byte(VEC[i].sel, a);
      any = a;
      for (int k = 0; k < 3; k++) begin
        if (k < int'(VEC[i].nb)) begin
          send_byte(VEC[i].dat[23 - 8*k -: 8], a);
          any = any | a;
          if (VEC[i].ack) chk("R11 data byte ack", {31'd0, a}, 32'd1);
        end
      end
      chk(VEC[i].ack ? "R11 selector ack" : "R3 later bytes no ack", {31'd0, any}, {31'd0, VEC[i].ack});
      bus_stop();
      tick(10);
      chk(row_tag(i), {24'd0, ctl}, {24'd0, VEC[i].e_ctl});
      chk(row_tag(i), {16'd0, rref}, {16'd0, VEC[i].e_ref});
      chk(row_tag(i), {16'd0, rmain}, {16'd0, VEC[i].e_main});
    end

    // R7: nothing visible before STOP; staging survives a repeated START
    strap = 1'b0;
    tick(4);
    bus_start();
    byte_chk("R11 address", 8'hC8, 1'b1);
    byte_chk("R11 selector", 8'h0C, 1'b1);
    byte_chk("R11 data", 8'h00, 1'b1);
    byte_chk("R11 data", 8'h07, 1'b1);
    tick(10);
    chk("R7 main held before stop", {16'd0, rmain}, 32'h1234);
    bus_start();
    byte_chk("R11 address after restart", 8'hC8, 1'b1);
    byte_chk("R11 selector", 8'h04, 1'b1);
    byte_chk("R11 data", 8'h5A, 1'b1);
    byte_chk("R11 data", 8'h00, 1'b1);
    byte_chk("R11 data", 8'h09, 1'b1);
    tick(10);
    chk("R7 ctl held before stop", {24'd0, ctl}, 32'h81);
    bus_stop();
    tick(10);
    chk("R7 main after stop", {16'd0, rmain}, 32'h0007);
    chk("R7 ref after stop", {16'd0, rref}, 32'h0009);
    chk("R6 ctl after stop", {24'd0, ctl}, 32'h5A);
    chk("R6 band select bit3", {31'd0, ctl[3]}, 32'd1);

    // R1: reset in the middle of operation clears everything
    rst_n = 1'b0;
    tick(3);
    chk("R1 outputs cleared", {ctl, rref, rmain} == 40'd0 ? 32'd1 : 32'd0, 32'd1);
    rst_n = 1'b1;
    tick(6);
    chk("R1 pull released", {31'd0, sda_pull}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule